// File: doc/BRIEF.md
# NaN Format Converter

This block carries a floating-point NaN from one binary format to another: half (16-bit), single (32-bit) or double (64-bit). The source word is first turned into a canonical form: a sign bit plus a 64-bit payload with the most significant fraction bit at bit 63. The result is then rebuilt in the destination format from that form. A payload that keeps at least one set bit after narrowing is passed through bit-aligned. A payload that loses all of its set bits falls back to the destination's default NaN. A default-NaN mode control makes every result the default NaN. A convention control selects what the top fraction bit means: with the control low, a set top bit marks a quiet NaN; with it high, a set top bit marks a signaling NaN.

The caller presents only NaN inputs. Deciding whether a value is a NaN happens upstream, and the block does not check it. The result and the invalid-operation flag are registered and appear one cycle after the input is accepted.

Top module: `nan_fmt_conv`

## Requirements
- R1: While rst_ni is low, valid_o, data_o and invalid_o are all zero.
- R2: valid_o equals valid_i of the previous cycle. data_o and invalid_o change only in the cycle after valid_i was high, and otherwise hold their values.
- R3: Format code 0 is half in bits 15:0, 1 is single in bits 31:0, 2 is double in bits 63:0, and 3 behaves as 2. Input bits above the source width are ignored. Output bits above the destination width are zero.
- R4: With default mode off, a conversion to a format of equal or greater width keeps the sign. It sets the exponent to all ones and places the source fraction in the top bits of the destination fraction, with zeros below.
- R5: With default mode off, a narrowing conversion keeps the most significant destination-width fraction bits and drops the rest. It does not set the quiet bit.
- R6: If the kept fraction bits are all zero, the output is the destination's default NaN.
- R7: With dnan_mode_i high, the output is always the destination's default NaN.
- R8: With qbit_inv_i low, the default NaNs are 0x7E00 (half), 0x7FC00000 (single) and 0x7FF8000000000000 (double).
- R9: With qbit_inv_i high, the default NaNs are 0x7DFF, 0x7FBFFFFF and 0x7FF7FFFFFFFFFFFF.
- R10: With qbit_inv_i low, invalid_o is set when the source exponent is all ones, the top fraction bit is clear and some lower fraction bit is set.
- R11: With qbit_inv_i high, invalid_o is set when the source exponent is all ones and the top fraction bit is set.
- R12: invalid_o depends only on the source word, its format and the convention. It does not depend on dnan_mode_i or on the destination format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word is valid |
| src_fmt_i | input | 2 | Source format code |
| dst_fmt_i | input | 2 | Destination format code |
| data_i | input | 64 | Source NaN, right-aligned |
| dnan_mode_i | input | 1 | Force default NaN output |
| qbit_inv_i | input | 1 | High: a set top fraction bit means signaling |
| valid_o | output | 1 | Result valid |
| data_o | output | 64 | Converted NaN, right-aligned |
| invalid_o | output | 1 | Source was a signaling NaN |

## Verification
The hardest case to reach is a narrowing conversion with default mode off in which every set payload bit sits in the part that is discarded. Only that case brings out the fallback to the default NaN, under each convention. The bench walks a single set bit across every fraction position of single and double sources into each destination, so that the boundary between kept and dropped bits is crossed on both sides. The bench also sweeps every half-precision fraction against every destination, convention and mode.

// File: rtl/nan_conv_pkg.sv
package nan_conv_pkg;
  localparam int CANON_W = 64;
  localparam int WORD_W  = 64;
  localparam int N_FMT   = 3;

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_ALIAS  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic               sign;
    logic [CANON_W-1:0] payload;
  } canon_t;

  function automatic int frac_w(int idx);
    case (idx)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

  function automatic int exp_w(int idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int canon_sh(int idx);
    return CANON_W - frac_w(idx);
  endfunction

  // code 3 folds onto double
  function automatic logic [1:0] fmt_sel(logic [1:0] f);
    return (f == FMT_ALIAS) ? 2'(FMT_DOUBLE) : f;
  endfunction

  function automatic logic [WORD_W-1:0] frac_mask(int idx);
    return (WORD_W'(1) << frac_w(idx)) - WORD_W'(1);
  endfunction

  function automatic logic [WORD_W-1:0] exp_mask(int idx);
    return ((WORD_W'(1) << exp_w(idx)) - WORD_W'(1)) << frac_w(idx);
  endfunction

  function automatic logic [WORD_W-1:0] word_mask(int idx);
    logic [WORD_W-1:0] m;
    m = frac_mask(idx) | exp_mask(idx);
    m = m | (WORD_W'(1) << (frac_w(idx) + exp_w(idx)));
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] dflt_nan(int idx, logic inv);
    logic [WORD_W-1:0] r;
    r = exp_mask(idx);
    if (inv) r = r | (frac_mask(idx) >> 1);
    else     r = r | (WORD_W'(1) << (frac_w(idx) - 1));
    return r;
  endfunction
endpackage

// File: rtl/nan_unpack.sv
module nan_unpack
  import nan_conv_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        sel_i,
  input  logic              qbit_inv_i,
  output canon_t            canon_o,
  output logic              snan_o
);
  canon_t           cand  [N_FMT];
  logic [N_FMT-1:0] snan_v;

  for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
    localparam int FW = frac_w(g);
    localparam int EW = exp_w(g);
    localparam int SH = canon_sh(g);
    logic e_ones, top, rest;

    assign e_ones = &word_i[FW+EW-1:FW];
    assign top    = word_i[FW-1];
    assign rest   = |word_i[FW-2:0];
    assign snan_v[g] = e_ones & (qbit_inv_i ? top : (~top & rest));

    // exponent and sign shift out past bit 63
    assign cand[g].sign    = word_i[FW+EW];
    assign cand[g].payload = word_i << SH;
  end

  always_comb begin
    canon_o = cand[N_FMT-1];
    snan_o  = snan_v[N_FMT-1];
    for (int k = 0; k < N_FMT; k++) begin
      if (sel_i == 2'(k)) begin
        canon_o = cand[k];
        snan_o  = snan_v[k];
      end
    end
  end
endmodule

// File: rtl/nan_pack.sv
module nan_pack
  import nan_conv_pkg::*;
(
  input  canon_t            canon_i,
  input  logic [1:0]        sel_i,
  input  logic              dnan_mode_i,
  input  logic              qbit_inv_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] cand [N_FMT];

  for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
    localparam int FW = frac_w(g);
    localparam int EW = exp_w(g);
    localparam int SH = canon_sh(g);
    logic [CANON_W-1:0] shifted;
    logic [FW-1:0]      mant;
    logic               lost;

    assign shifted = canon_i.payload >> SH;
    assign mant    = FW'(shifted);
    assign lost    = (shifted == '0);
    // no re-quieting on narrowing: truncated payload passes as is
    assign cand[g] = (dnan_mode_i || lost) ? dflt_nan(g, qbit_inv_i)
                                           : WORD_W'({canon_i.sign, {EW{1'b1}}, mant});
  end

  always_comb begin
    word_o = cand[N_FMT-1];
    for (int k = 0; k < N_FMT; k++) begin
      if (sel_i == 2'(k)) word_o = cand[k];
    end
  end
endmodule

// File: rtl/nan_fmt_conv.sv
module nan_fmt_conv
  import nan_conv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        src_fmt_i,
  input  logic [1:0]        dst_fmt_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              dnan_mode_i,
  input  logic              qbit_inv_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              invalid_o
);
  logic [1:0]        src_sel, dst_sel;
  canon_t            canon;
  logic              snan;
  logic [WORD_W-1:0] conv;

  assign src_sel = fmt_sel(src_fmt_i);
  assign dst_sel = fmt_sel(dst_fmt_i);

  nan_unpack i_unpack (
    .word_i     (data_i),
    .sel_i      (src_sel),
    .qbit_inv_i (qbit_inv_i),
    .canon_o    (canon),
    .snan_o     (snan)
  );

  nan_pack i_pack (
    .canon_i     (canon),
    .sel_i       (dst_sel),
    .dnan_mode_i (dnan_mode_i),
    .qbit_inv_i  (qbit_inv_i),
    .word_o      (conv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      data_o    <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o    <= conv;
        invalid_o <= snan;
      end
    end
  end
endmodule

// File: rtl/nan_fmt_conv_chk.sv
module nan_fmt_conv_chk
  import nan_conv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        src_fmt_i,
  input logic [1:0]        dst_fmt_i,
  input logic [WORD_W-1:0] data_i,
  input logic              dnan_mode_i,
  input logic              qbit_inv_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] data_o,
  input logic              invalid_o
);
  logic [1:0] s_sel, d_sel;
  assign s_sel = fmt_sel(src_fmt_i);
  assign d_sel = fmt_sel(dst_fmt_i);

  assert_valid_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_dn_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(data_o) && $stable(invalid_o)));

  assert_half_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && d_sel == 2'd0) |=> (data_o[WORD_W-1:16] == '0));

  assert_single_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && d_sel == 2'd1) |=> (data_o[WORD_W-1:32] == '0));

  assert_dnan_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dnan_mode_i) |=>
      (data_o == dflt_nan(int'($past(d_sel)), $past(qbit_inv_i))));

  assert_same_fmt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dnan_mode_i && s_sel == d_sel && (data_i & frac_mask(int'(s_sel))) != '0) |=>
      (data_o == (($past(data_i) & word_mask(int'($past(d_sel)))) | exp_mask(int'($past(d_sel))))));
endmodule

bind nan_fmt_conv nan_fmt_conv_chk i_chk (.*);

// File: tb/test_nan_fmt_conv.sv
`timescale 1ns/1ps
module test_nan_fmt_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  src_fmt = '0, dst_fmt = '0;
  logic [63:0] data_i = '0;
  logic        dnan = 1'b0, qinv = 1'b0;
  logic        valid_o, invalid_o;
  logic [63:0] data_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nan_fmt_conv i_nan_fmt_conv (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .src_fmt_i(src_fmt),
    .dst_fmt_i(dst_fmt), .data_i(data_i), .dnan_mode_i(dnan), .qbit_inv_i(qinv),
    .valid_o(valid_o), .data_o(data_o), .invalid_o(invalid_o)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int fw(int c);
    return (c == 0) ? 10 : (c == 1) ? 23 : 52;
  endfunction
  function automatic int ew(int c);
    return (c == 0) ? 5 : (c == 1) ? 8 : 11;
  endfunction
  function automatic logic [63:0] dn_const(int c, bit inv);
    if (c == 0) return inv ? 64'h7DFF : 64'h7E00;
    if (c == 1) return inv ? 64'h7FBF_FFFF : 64'h7FC0_0000;
    return inv ? 64'h7FF7_FFFF_FFFF_FFFF : 64'h7FF8_0000_0000_0000;
  endfunction

  function automatic void model(input int s, input int d, input logic [63:0] w,
                                input bit dm, input bit inv,
                                output logic [63:0] o, output bit sn, output string tg);
    int fs = fw(s), es = ew(s), fd = fw(d), ed = ew(d);
    logic [63:0] fr, ofr, eo;
    bit top, rest, eones, sg;
    fr    = w & ((64'd1 << fs) - 64'd1);
    sg    = w[fs+es];
    top   = fr[fs-1];
    rest  = (fr & ((64'd1 << (fs-1)) - 64'd1)) != 0;
    eo    = (64'd1 << es) - 64'd1;
    eones = ((w >> fs) & eo) == eo;
    sn    = eones && (inv ? top : (!top && rest));
    if (fd >= fs) ofr = fr << (fd - fs);
    else          ofr = fr >> (fs - fd);
    if (dm) begin
      o = dn_const(d, inv); tg = "R7";
    end else if (ofr == 0) begin
      o = dn_const(d, inv); tg = "R6";
    end else begin
      o = (64'(sg) << (fd + ed)) | (((64'd1 << ed) - 64'd1) << fd) | ofr;
      tg = (fd < fs) ? "R5" : "R4";
    end
  endfunction

  // called at a negedge; checks at the following negedge
  task automatic run(int s, int d, logic [63:0] w, bit dm, bit inv);
    logic [63:0] eo;
    bit esn;
    string tg;
    src_fmt = 2'(s); dst_fmt = 2'(d); data_i = w; dnan = dm; qinv = inv; valid_i = 1'b1;
    @(negedge clk);
    model((s > 2) ? 2 : s, (d > 2) ? 2 : d, w, dm, inv, eo, esn, tg);
    if (s > 2 || d > 2) tg = "R3";
    chk(tg, data_o, eo);
    chk(dm ? "R12" : (inv ? "R11" : "R10"), 64'(invalid_o), 64'(esn));
    chk("R2", 64'(valid_o), 64'd1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 64'(valid_o), 64'd0);
    chk("R1", data_o, 64'd0);
    chk("R1", 64'(invalid_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // every half fraction, garbage above bit 15 (R3)
    for (int f = 1; f < 1024; f++)
      for (int sg = 0; sg < 2; sg++)
        for (int d = 0; d < 3; d++)
          for (int iv = 0; iv < 2; iv++)
            for (int m = 0; m < 2; m++)
              run(0, d, {48'hA5C3_9E17_0F2B ^ 48'(f), 1'(sg), 5'h1F, 10'(f)}, m[0], iv[0]);

    // single: walking bit plus dense patterns
    for (int b = 0; b < 25; b++) begin
      logic [22:0] fr;
      fr = (b < 23) ? (23'd1 << b) : ((b == 23) ? 23'h7F_FFFF : 23'h2A_5A5A);
      for (int sg = 0; sg < 2; sg++)
        for (int d = 0; d < 3; d++)
          for (int iv = 0; iv < 2; iv++)
            for (int m = 0; m < 2; m++)
              run(1, d, {32'h5A3C_C3A5, 1'(sg), 8'hFF, fr}, m[0], iv[0]);
    end

    // double: walking bit plus dense patterns
    for (int b = 0; b < 54; b++) begin
      logic [51:0] fr;
      fr = (b < 52) ? (52'd1 << b) : ((b == 52) ? {52{1'b1}} : 52'h8_0000_0000_0001);
      for (int sg = 0; sg < 2; sg++)
        for (int d = 0; d < 3; d++)
          for (int iv = 0; iv < 2; iv++)
            for (int m = 0; m < 2; m++)
              run(2, d, {1'(sg), 11'h7FF, fr}, m[0], iv[0]);
    end

    // format code 3 aliases double (R3)
    run(3, 3, 64'hFFF4_0000_0000_0123, 1'b0, 1'b0);
    run(2, 3, 64'h7FFC_0000_0000_0000, 1'b0, 1'b1);
    run(3, 0, 64'h7FF0_1000_0000_0000, 1'b0, 1'b0);
    run(1, 3, 64'h0000_0000_FF80_0001, 1'b1, 1'b1);

    // literal default NaNs (R8, R9)
    for (int d = 0; d < 3; d++) begin
      run(1, d, 64'h7FC0_0001, 1'b1, 1'b0);
      chk("R8", data_o, (d == 0) ? 64'h7E00 : (d == 1) ? 64'h7FC0_0000 : 64'h7FF8_0000_0000_0000);
      run(1, d, 64'h7FC0_0001, 1'b1, 1'b1);
      chk("R9", data_o, (d == 0) ? 64'h7DFF : (d == 1) ? 64'h7FBF_FFFF : 64'h7FF7_FFFF_FFFF_FFFF);
    end

    // hold while idle (R2): half sNaN -> single, then change inputs with valid low
    run(0, 1, 64'h7C01, 1'b0, 1'b0);
    valid_i = 1'b0; data_i = 64'h7E00; dnan = 1'b1; src_fmt = 2'd2; dst_fmt = 2'd0;
    @(negedge clk);
    @(negedge clk);
    chk("R2", 64'(valid_o), 64'd0);
    chk("R2", data_o, 64'h7F80_2000);
    chk("R2", 64'(invalid_o), 64'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule